// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block is one DMA channel. Software sets it up through a small register port: an 8-bit control word, a source start address, a destination start address and a transfer count. Four request lines come in from peripherals. The control word picks one of them, and a rising edge on the picked line starts one transfer. A transfer is a single read from the source address on a simple memory bus, followed by a single write of the returned data to the destination address. Each bus phase holds its strobe until the bus answers with a one-cycle done pulse.

After each transfer, each address either stays where it is or advances. The step is 1 for byte units and 2 for halfword units.

The channel has two modes:
- **Counted mode:** the count drops by one per transfer. When it reaches zero, the channel pulses a finished interrupt and switches itself off.
- **Ring mode:** both addresses return to their start values after every 32 transfers. The count runs free, no interrupt is raised, and the channel keeps serving requests until software clears the enable bit.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the control word reads 0, `bus_rd`, `bus_wr` and `fin_irq` are low, and no bus cycle starts.
- R2: An accepted request makes one read at the current source address. It is followed, after `bus_done`, by one write of the returned data to the current destination address. Each strobe stays high until its `bus_done`, and `bus_rd` and `bus_wr` are never high together.
- R3: Control bit 5 selects the unit: 0 is 16-bit with an address step of 2, and 1 is 8-bit with a step of 1 (only `bus_wdata[7:0]` is kept, the upper bits are 0). Bit 6 (source) and bit 7 (destination) select the address policy: 1 is increment and 0 is fixed.
- R4: Control bits 3:2 give the index of the `req_src` line that triggers the channel. Only a rising edge on that line, seen at the clock, is a request. Edges on the other lines have no effect.
- R5: While control bit 4 (enable) is 0, request edges are ignored: there is no bus activity and the flag does not change.
- R6: Control bit 1 is a request flag. Hardware sets it to 1 when it accepts a request. A control write with bit 1 = 0 clears it, and a write with bit 1 = 1 leaves it unchanged.
- R7: A request is accepted only while no request is latched and no transfer is running. Edges that arrive in between are dropped, not queued.
- R8: Clearing the enable bit after a request has been accepted does not abort it. That transfer completes, and later requests are ignored.
- R9: In counted mode (control bit 0 = 0), each transfer decrements the count. The transfer that brings it from 1 to 0 raises `fin_irq` for exactly one cycle and clears the enable bit in the same cycle.
- R10: In ring mode (control bit 0 = 1), the addresses go back to their start values after every 32 transfers. The count keeps decrementing with wrap-around, `fin_irq` never rises, and the enable bit stays set.
- R11: `cfg_sel` selects the register: 0 is control, 1 is source address, 2 is destination address, 3 is count.
  - Writing an address sets both its start value and its current value, and also restarts the 32-transfer ring period.
  - Reads show the current addresses. `cfg_rdata` follows `cfg_sel` combinationally, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_src | input | 4 | Peripheral request lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational) |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_byte | output | 1 | 1 = 8-bit unit, 0 = 16-bit unit |
| bus_addr | output | AW | Memory address |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data, valid with bus_done during a read |
| bus_done | input | 1 | One-cycle completion of the current bus phase |
| fin_irq | output | 1 | One-cycle finished interrupt in counted mode |

## Verification
The transfer path is driven with several mixes:
- **Halfword units with both addresses incrementing**, which separates a step of 2 from a step of 1.
- **Byte units with a fixed source**, which shows that the policy bits act independently and that the upper data byte is masked.
- **A 34-transfer ring run**, whose 33rd and 34th transfers show the reload at 32, the absence of an interrupt and the free-running count.
- **Randomized setups** with random bus latency, random request line, random counts and random policy bits, which test the address and data sequence against a bench model.

Directed cases cover:
- edges on unselected lines;
- edges while the channel is disabled;
- bursts of edges during a stalled transfer;
- a disable issued mid-transfer;
- flag writes of both polarities.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int REQ_SRCS  = 4;
    localparam int REQ_SEL_W = 2;

    // control word bit positions
    localparam int CTL_MODE = 0;
    localparam int CTL_FLAG = 1;
    localparam int CTL_SELL = 2;
    localparam int CTL_EN   = 4;
    localparam int CTL_BYTE = 5;
    localparam int CTL_SINC = 6;
    localparam int CTL_DINC = 7;

    localparam logic [1:0] REG_CTL = 2'd0;
    localparam logic [1:0] REG_SRC = 2'd1;
    localparam logic [1:0] REG_DST = 2'd2;
    localparam logic [1:0] REG_CNT = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_e;
endpackage

// File: rtl/dma_req_edge.sv
module dma_req_edge #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  req,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [NSRC-1:0] prev_d, prev_q;
    logic [NSRC-1:0] rise;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
        hit    = rise[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] start,
    input  logic          inc_en,
    input  logic          byte_unit,
    input  logic          wrap,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_H = AW'(2);

    always_comb begin
        if (wrap)        nxt = start;
        else if (inc_en) nxt = cur + (byte_unit ? STEP_B : STEP_H);
        else             nxt = cur;
    end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int CNT_W    = 8,
    parameter int RING_LEN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REQ_SRCS-1:0] req_src,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [DW-1:0]       cfg_wdata,
    output logic [DW-1:0]       cfg_rdata,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic                bus_byte,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       bus_wdata,
    input  logic [DW-1:0]       bus_rdata,
    input  logic                bus_done,
    output logic                fin_irq
);
    localparam int RW = $clog2(RING_LEN);

    typedef struct packed {
        xfer_st_e       st;
        logic [7:0]     ctl;
        logic           pend;
        logic [AW-1:0]  src_start;
        logic [AW-1:0]  dst_start;
        logic [AW-1:0]  src_cur;
        logic [AW-1:0]  dst_cur;
        logic [CNT_W-1:0] cnt;
        logic [RW-1:0]  ring;
        logic [DW-1:0]  data;
        logic           irq;
    } chan_t;

    chan_t d, q;
    logic        req_hit;
    logic        accept;
    logic        ring_wrap;
    logic [AW-1:0] cur_a   [2];
    logic [AW-1:0] start_a [2];
    logic [AW-1:0] nxt_a   [2];
    logic [1:0]    inc_a;
    logic [7:0]    ctl_q;

    dma_req_edge #(.NSRC(REQ_SRCS), .SEL_W(REQ_SEL_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_src),
        .sel   (q.ctl[CTL_SELL +: REQ_SEL_W]),
        .hit   (req_hit)
    );

    assign ring_wrap  = q.ctl[CTL_MODE] && (q.ring == RW'(RING_LEN - 1));
    assign cur_a[0]   = q.src_cur;
    assign cur_a[1]   = q.dst_cur;
    assign start_a[0] = q.src_start;
    assign start_a[1] = q.dst_start;
    assign inc_a      = {q.ctl[CTL_DINC], q.ctl[CTL_SINC]};

    // one address stepper per side: index 0 source, index 1 destination
    for (genvar g = 0; g < 2; g++) begin : g_step
        dma_addr_step #(.AW(AW)) u_step (
            .cur       (cur_a[g]),
            .start     (start_a[g]),
            .inc_en    (inc_a[g]),
            .byte_unit (q.ctl[CTL_BYTE]),
            .wrap      (ring_wrap),
            .nxt       (nxt_a[g])
        );
    end

    always_comb begin
        d     = q;
        d.irq = 1'b0;

        if (cfg_we) begin
            case (cfg_sel)
                REG_CTL: begin
                    d.ctl           = cfg_wdata[7:0];
                    d.ctl[CTL_FLAG] = q.ctl[CTL_FLAG] & cfg_wdata[CTL_FLAG];
                end
                REG_SRC: begin
                    d.src_start = cfg_wdata[AW-1:0];
                    d.src_cur   = cfg_wdata[AW-1:0];
                    d.ring      = '0;
                end
                REG_DST: begin
                    d.dst_start = cfg_wdata[AW-1:0];
                    d.dst_cur   = cfg_wdata[AW-1:0];
                    d.ring      = '0;
                end
                default: d.cnt = cfg_wdata[CNT_W-1:0];
            endcase
        end

        accept = req_hit && q.ctl[CTL_EN] && !q.pend && (q.st == ST_IDLE);
        if (accept) begin
            d.pend          = 1'b1;
            d.ctl[CTL_FLAG] = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (q.pend) begin
                    d.st   = ST_RD;
                    d.pend = 1'b0;
                end
            end
            ST_RD: begin
                if (bus_done) begin
                    d.data = bus_rdata;
                    d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (bus_done) begin
                    d.st      = ST_IDLE;
                    d.src_cur = nxt_a[0];
                    d.dst_cur = nxt_a[1];
                    d.cnt     = q.cnt - CNT_W'(1);
                    if (q.ctl[CTL_MODE]) begin
                        d.ring = ring_wrap ? '0 : q.ring + RW'(1);
                    end else if (q.cnt == CNT_W'(1)) begin
                        d.irq         = 1'b1;
                        d.ctl[CTL_EN] = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (cfg_sel)
            REG_CTL: cfg_rdata = DW'(q.ctl);
            REG_SRC: cfg_rdata = DW'(q.src_cur);
            REG_DST: cfg_rdata = DW'(q.dst_cur);
            default: cfg_rdata = DW'(q.cnt);
        endcase
    end

    assign ctl_q     = q.ctl;
    assign bus_rd    = (q.st == ST_RD);
    assign bus_wr    = (q.st == ST_WR);
    assign bus_byte  = q.ctl[CTL_BYTE];
    assign bus_addr  = (q.st == ST_WR) ? q.dst_cur : q.src_cur;
    assign bus_wdata = q.ctl[CTL_BYTE] ? DW'(q.data[7:0]) : q.data;
    assign fin_irq   = q.irq;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       bus_done,
    input logic       fin_irq,
    input logic [7:0] ctl_q,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic [7:0] cfg_wlo
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_done) |=> bus_rd);

    assert_rd_to_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_done) |=> bus_wr);

    assert_wr_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_done) |=> (!bus_wr && !bus_rd));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[1] && !(cfg_we && cfg_sel == 2'd0 && !cfg_wlo[1])) |=> ctl_q[1]);

    assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_irq |=> !fin_irq);

    assert_irq_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fin_irq |-> !ctl_q[4]);

    assert_ring_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fin_irq |-> !$past(ctl_q[0]));
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_done (bus_done),
    .fin_irq  (fin_irq),
    .ctl_q    (ctl_q),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wlo  (cfg_wdata[7:0])
);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    req_src;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [DW-1:0] cfg_wdata;
    logic [DW-1:0] cfg_rdata;
    logic          bus_rd, bus_wr, bus_byte;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_done;
    logic          fin_irq;

    always #5 clk = ~clk;

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .req_src(req_src),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done), .fin_irq(fin_irq)
    );

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0, both_cnt = 0;
    bit hold = 1'b0;
    logic [AW-1:0] rd_log [512];
    logic [AW-1:0] wa_log [512];
    logic [DW-1:0] wd_log [512];

    function automatic logic [DW-1:0] rd_fn(input logic [AW-1:0] a);
        return DW'(a) ^ 16'hC3A5;
    endfunction

    function automatic logic [7:0] mk_ctl(input bit dinc, input bit sinc, input bit byt,
                                          input bit en, input int sel, input bit ring);
        return {dinc, sinc, byt, en, 2'(sel), 1'b0, ring};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s, input bit inc,
                                               input bit byt, input bit ring, input int i);
        int k;
        k = ring ? (i % 32) : i;
        return inc ? AW'(s + (byt ? 1 : 2) * k) : s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus responder with random latency
    initial begin
        int dly;
        dly = 0;
        bus_done = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_rd && bus_wr) both_cnt++;
            if (fin_irq) irq_cnt++;
            if (bus_done) bus_done = 1'b0;
            else if ((bus_rd || bus_wr) && !hold) begin
                if (dly == 0) begin
                    bus_done = 1'b1;
                    if (bus_rd) begin
                        bus_rdata = rd_fn(bus_addr);
                        rd_log[rd_cnt % 512] = bus_addr;
                        rd_cnt++;
                    end else begin
                        wa_log[wr_cnt % 512] = bus_addr;
                        wd_log[wr_cnt % 512] = bus_wdata;
                        wr_cnt++;
                    end
                    dly = $urandom % 3;
                end else dly--;
            end
        end
    end

    task automatic cfg_wr(input logic [1:0] sel, input logic [DW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [1:0] sel, output logic [DW-1:0] v);
        @(negedge clk);
        cfg_sel = sel;
        #1 v = cfg_rdata;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk); req_src[idx] = 1'b1;
        @(negedge clk); req_src[idx] = 1'b0;
    endtask

    task automatic wait_wr(input int target, input string req);
        int t;
        t = 0;
        while (wr_cnt < target && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(wr_cnt >= target, req, wr_cnt, target);
        repeat (3) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // program and run n transfers, then compare the logs against the model
    task automatic run_set(input string req, input int n, input logic [AW-1:0] s0,
                           input logic [AW-1:0] d0, input bit sinc, input bit dinc,
                           input bit byt, input bit ring, input int sel, input int cnt);
        int base;
        cfg_wr(2'd1, s0);
        cfg_wr(2'd2, d0);
        cfg_wr(2'd3, DW'(cnt));
        cfg_wr(2'd0, DW'(mk_ctl(dinc, sinc, byt, 1'b1, sel, ring)));
        base = wr_cnt;
        for (int i = 0; i < n; i++) begin
            pulse(sel);
            wait_wr(base + i + 1, req);
        end
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] es, ed;
            logic [DW-1:0] ev;
            es = exp_addr(s0, sinc, byt, ring, i);
            ed = exp_addr(d0, dinc, byt, ring, i);
            ev = byt ? DW'(rd_fn(es) & 16'h00FF) : rd_fn(es);
            chk(rd_log[(base + i) % 512] == es, {req, " src addr"}, rd_log[(base + i) % 512], es);
            chk(wa_log[(base + i) % 512] == ed, {req, " dst addr"}, wa_log[(base + i) % 512], ed);
            chk(wd_log[(base + i) % 512] == ev, {req, " data"}, wd_log[(base + i) % 512], ev);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int irq0, w0;
        void'($urandom(32'd1234));
        rst_n = 1'b0; req_src = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        cfg_rd(2'd0, v);
        chk(v == 0, "R1 ctl", v, 0);
        chk(!bus_rd && !bus_wr && !fin_irq, "R1 strobes", {bus_rd, bus_wr, fin_irq}, 0);

        // R2 R3 R9: halfword, both increment, count 5
        irq0 = irq_cnt;
        run_set("R2 R3 halfword inc", 4, 16'h1000, 16'h2000, 1, 1, 0, 0, 1, 5);
        chk(irq_cnt == irq0, "R9 no early irq", irq_cnt - irq0, 0);
        pulse(1);
        wait_wr(wr_cnt + 1, "R9 last transfer");
        chk(irq_cnt == irq0 + 1, "R9 one irq", irq_cnt - irq0, 1);
        cfg_rd(2'd0, v);
        chk(v[4] == 1'b0, "R9 enable cleared", v[4], 0);
        chk(v[1] == 1'b1, "R6 flag set", v[1], 1);
        cfg_rd(2'd3, v);
        chk(v == 0, "R9 count zero", v, 0);
        cfg_rd(2'd1, v);
        chk(v == 16'h100A, "R11 src current", v, 16'h100A);

        // R6 write 1 keeps flag, write 0 clears
        cfg_wr(2'd0, 16'h0002);
        cfg_rd(2'd0, v);
        chk(v[1] == 1'b1, "R6 write one keeps", v[1], 1);
        cfg_wr(2'd0, 16'h0000);
        cfg_rd(2'd0, v);
        chk(v[1] == 1'b0, "R6 write zero clears", v[1], 0);

        // R3: byte unit, source fixed, destination increment
        run_set("R3 byte fixed src", 3, 16'h3001, 16'h4003, 0, 1, 1, 0, 2, 3);

        // R10 ring: 34 transfers, count 3
        irq0 = irq_cnt;
        run_set("R10 ring wrap", 34, 16'h5000, 16'h6000, 1, 1, 0, 1, 0, 3);
        chk(irq_cnt == irq0, "R10 no irq", irq_cnt - irq0, 0);
        cfg_rd(2'd0, v);
        chk(v[4] == 1'b1, "R10 enable kept", v[4], 1);
        cfg_rd(2'd3, v);
        chk(v == 16'h00E1, "R10 count free-runs", v, 16'h00E1);

        // R4: only the selected line triggers
        cfg_wr(2'd3, 16'd9);
        cfg_wr(2'd0, DW'(mk_ctl(1, 1, 0, 1, 2, 0)));
        w0 = wr_cnt;
        pulse(0); pulse(1); pulse(3); idle(20);
        chk(wr_cnt == w0 && rd_cnt == w0, "R4 other lines ignored", wr_cnt - w0, 0);
        pulse(2);
        wait_wr(w0 + 1, "R4 selected line");

        // R5: disabled channel ignores requests
        cfg_wr(2'd0, DW'(mk_ctl(1, 1, 0, 0, 2, 0)));
        cfg_wr(2'd0, 16'h0000 | DW'(mk_ctl(1, 1, 0, 0, 2, 0)));
        w0 = wr_cnt;
        pulse(2); idle(20);
        chk(wr_cnt == w0, "R5 disabled no transfer", wr_cnt - w0, 0);
        cfg_rd(2'd0, v);
        chk(v[1] == 1'b0, "R5 flag untouched", v[1], 0);

        // R7: extra edges during a stalled transfer are dropped
        cfg_wr(2'd0, DW'(mk_ctl(1, 1, 0, 1, 3, 0)));
        hold = 1'b1;
        w0 = wr_cnt;
        pulse(3); idle(2);
        pulse(3); pulse(3);
        hold = 1'b0;
        wait_wr(w0 + 1, "R7 first transfer");
        idle(30);
        chk(wr_cnt == w0 + 1, "R7 extra edges dropped", wr_cnt - w0, 1);

        // R8: disable during an accepted transfer
        hold = 1'b1;
        w0 = wr_cnt;
        pulse(3);
        while (!bus_rd) @(negedge clk);
        cfg_wr(2'd0, DW'(mk_ctl(1, 1, 0, 0, 3, 0)));
        hold = 1'b0;
        wait_wr(w0 + 1, "R8 transfer completes");
        pulse(3); idle(20);
        chk(wr_cnt == w0 + 1, "R8 later request ignored", wr_cnt - w0, 1);

        // random setups in counted mode
        for (int r = 0; r < 6; r++) begin
            int n, sel;
            bit si, di, by;
            logic [AW-1:0] s0, d0;
            n = 1 + ($urandom % 5);
            sel = $urandom % 4;
            si = 1'($urandom); di = 1'($urandom); by = 1'($urandom);
            s0 = AW'($urandom) & 16'h7FFE;
            d0 = AW'($urandom) & 16'h7FFE;
            irq0 = irq_cnt;
            run_set("R2 R3 random", n, s0, d0, si, di, by, 0, sel, n);
            chk(irq_cnt == irq0 + 1, "R9 random irq", irq_cnt - irq0, 1);
        end

        chk(both_cnt == 0, "R2 strobes exclusive", both_cnt, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule